// File: doc/BRIEF.md
# DS3 idle and FERF alarm detector

This block sits behind a DS3 receive framer that has already found frame alignment and pulled the overhead bits out of each M-frame. On the closing cycle of every M-frame the framer raises a one-cycle end-of-frame strobe. In that same cycle it presents the frame's overhead summary: whether the M-, F- and P-bits were valid, the three CP-bits and the two X-bits. During the frame it streams the payload bits one at a time, each qualified by a valid flag.

The block decides whether each frame is an idle-signal frame. It feeds that verdict into a saturating up/down counter, which declares and clears the Idle alarm with hysteresis. In parallel it tracks the far-end receive failure (yellow alarm) from the X-bits. Each alarm reports its changes as a one-cycle interrupt pulse. The block also assembles a read-only status byte that merges the Idle alarm with alarm and configuration bits supplied from neighbouring logic.

The payload input is a valid/ready stream. The block never applies back-pressure: `pay_ready` is held at 1, and every cycle with `pay_valid` high delivers exactly one payload bit. This includes a bit presented in the end-of-frame cycle, which belongs to the frame that is closing.

Top module: `ds3_idle_ferf_mon`

## Requirements
- R1: After reset the Idle counter is 0, and `idle`, `ferf`, `idle_irq` and `ferf_irq` are all 0.
- R2: A frame qualifies as idle only when all of the following hold: `m_ok`, `f_ok` and `p_ok` are all 1; `cp_bits` equals 3'b000; `x_bits` equals 2'b11; and the payload check of R3 passes. Any single failure makes it a non-idle frame.
- R3: The payload check accepts the 1100 sequence in any of its four rotations. Every payload bit from the third of the frame onward must be the inverse of the bit two positions earlier. A frame with fewer than three payload bits passes. The check restarts at each end-of-frame strobe, and a bit accepted in the strobe cycle counts toward the closing frame.
- R4: At each strobe the Idle counter goes up by one for an idle frame and down by one for a non-idle frame. It stays at 0 instead of going below 0, and stays at 63 instead of going above 63.
- R5: `idle` is set when the counter reaches 63 and cleared when the counter reaches 0. Between those points it keeps its value.
- R6: `idle_irq` is high for exactly the one cycle after each clock edge on which `idle` changed, in either direction, and is low at all other times.
- R7: At each strobe, `ferf` is set if `x_bits` is 2'b00 and cleared otherwise. `ferf_irq` pulses for one cycle whenever `ferf` changes.
- R8: Without a strobe, the overhead inputs (`m_ok`, `f_ok`, `p_ok`, `cp_bits`, `x_bits`) have no effect: the counter, `idle` and `ferf` keep their values.
- R9: `stat_byte` bit 7 is `ais_in`, bit 6 is `los_in`, bit 5 is `idle`, bit 4 is `oof_in`, bit 3 reads 0, and bits 2..0 are `cfg_in`.
- R10: `pay_ready` is 1 in every cycle, so no payload bit is ever held off.
- R11: All counter and alarm updates take effect on the clock edge that samples the strobe, and are visible in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof | input | 1 | End-of-M-frame strobe, one cycle |
| m_ok | input | 1 | M-bits of the frame were valid |
| f_ok | input | 1 | F-bits of the frame were valid |
| p_ok | input | 1 | P-bits of the frame were valid |
| cp_bits | input | 3 | CP-bits of the frame |
| x_bits | input | 2 | X-bits of the frame |
| pay_valid | input | 1 | Payload bit is present |
| pay_bit | input | 1 | Payload bit value |
| pay_ready | output | 1 | Payload accept, always 1 |
| ais_in | input | 1 | AIS alarm from a neighbour, shown in the status byte |
| los_in | input | 1 | LOS alarm from a neighbour, shown in the status byte |
| oof_in | input | 1 | Out-of-frame flag from a neighbour, shown in the status byte |
| cfg_in | input | 3 | Configuration bits shown in the status byte |
| idle | output | 1 | Idle alarm |
| ferf | output | 1 | Far-end receive failure alarm |
| idle_irq | output | 1 | One-cycle pulse on each Idle change |
| ferf_irq | output | 1 | One-cycle pulse on each FERF change |
| stat_byte | output | 8 | Read-only status byte |

## Verification
The assertions assume that `eof` never stays high on two consecutive cycles. This assumption is itself checked as a property on the input. Without it, a strobe could land while the previous change pulse is still high, and the one-cycle pulse properties for R6 and R7 would not be meaningful. The stimulus leaves at least one strobe-free cycle after every frame. Between strobes it drives the overhead inputs with values that would be disqualifying (all-zero X-bits and random CP-bits), so that any leak between strobes shows up at the outputs. It also sends payload bits with gaps in `pay_valid`, and sometimes places the last payload bit in the strobe cycle itself.

// File: rtl/ds3_alm_pkg.sv
package ds3_alm_pkg;

  // Overhead summary delivered with each end-of-frame strobe.
  typedef struct packed {
    logic       m_ok;
    logic       f_ok;
    logic       p_ok;
    logic [2:0] cp;
    logic [1:0] x;
  } ovh_t;

  localparam logic [1:0] X_IDLE = 2'b11;
  localparam logic [1:0] X_FERF = 2'b00;

  // Overhead part of the idle qualification (R2).
  function automatic logic ovh_is_idle(input ovh_t o);
    return o.m_ok && o.f_ok && o.p_ok && (o.cp == 3'b000) && (o.x == X_IDLE);
  endfunction

endpackage

// File: rtl/ds3_idle_pat.sv
// Phase-free payload check: every bit from the third on must be the inverse
// of the bit two positions back, which holds for every rotation of 1100.
module ds3_idle_pat (
  input  logic clk,
  input  logic rst_n,
  input  logic eof,
  input  logic pay_valid,
  input  logic pay_bit,
  output logic pat_ok
);
  logic [1:0] seen;   // payload bits seen so far, saturating at 2
  logic [1:0] hist;   // [0] = latest bit, [1] = the one before
  logic       mis;
  logic       bit_ok;

  assign bit_ok = !(pay_valid && (seen == 2'd2) && (pay_bit == hist[1]));
  // A bit in the strobe cycle still counts toward the closing frame.
  assign pat_ok = !mis && bit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || eof) begin
      seen <= 2'd0;
      hist <= 2'b00;
      mis  <= 1'b0;
    end else if (pay_valid) begin
      hist <= {hist[0], pay_bit};
      if (seen != 2'd2) seen <= seen + 2'd1;
      if (!bit_ok) mis <= 1'b1;
    end
  end
endmodule

// File: rtl/ds3_idle_integ.sv
// Saturating up/down frame integrator, with declare and clear points for Idle.
module ds3_idle_integ #(
  parameter int THRESH = 63
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         eof,
  input  logic                         qual,
  output logic [$clog2(THRESH+1)-1:0]  cnt,
  output logic                         idle,
  output logic                         idle_irq
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] CMAX = CW'(THRESH);

  logic [CW-1:0] cnt_nx;
  logic          idle_nx;

  always_comb begin
    cnt_nx  = cnt;
    idle_nx = idle;
    if (eof) begin
      if (qual && cnt != CMAX)              cnt_nx = cnt + 1'b1;
      else if (!qual && cnt != '0)          cnt_nx = cnt - 1'b1;
      if (cnt_nx == CMAX)                   idle_nx = 1'b1;
      else if (cnt_nx == '0)                idle_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      idle     <= 1'b0;
      idle_irq <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      idle     <= idle_nx;
      idle_irq <= idle_nx ^ idle;
    end
  end
endmodule

// File: rtl/ds3_ferf_det.sv
// Yellow alarm follows the X-bits of each frame, sampled at the strobe.
module ds3_ferf_det
  import ds3_alm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eof,
  input  logic [1:0] x_bits,
  output logic       ferf,
  output logic       ferf_irq
);
  logic ferf_nx;

  assign ferf_nx = eof ? (x_bits == X_FERF) : ferf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ferf     <= 1'b0;
      ferf_irq <= 1'b0;
    end else begin
      ferf     <= ferf_nx;
      ferf_irq <= ferf_nx ^ ferf;
    end
  end
endmodule

// File: rtl/ds3_idle_ferf_mon.sv
module ds3_idle_ferf_mon
  import ds3_alm_pkg::*;
#(
  parameter int THRESH = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eof,
  input  logic       m_ok,
  input  logic       f_ok,
  input  logic       p_ok,
  input  logic [2:0] cp_bits,
  input  logic [1:0] x_bits,
  input  logic       pay_valid,
  input  logic       pay_bit,
  output logic       pay_ready,
  input  logic       ais_in,
  input  logic       los_in,
  input  logic       oof_in,
  input  logic [2:0] cfg_in,
  output logic       idle,
  output logic       ferf,
  output logic       idle_irq,
  output logic       ferf_irq,
  output logic [7:0] stat_byte
);
  localparam int CW = $clog2(THRESH + 1);

  ovh_t          ovh;
  logic          pat_ok;
  logic          qual;
  logic [CW-1:0] idle_cnt;

  assign ovh       = '{m_ok: m_ok, f_ok: f_ok, p_ok: p_ok, cp: cp_bits, x: x_bits};
  assign qual      = ovh_is_idle(ovh) && pat_ok;
  assign pay_ready = 1'b1;

  ds3_idle_pat u_pat (
    .clk(clk), .rst_n(rst_n), .eof(eof),
    .pay_valid(pay_valid), .pay_bit(pay_bit), .pat_ok(pat_ok)
  );

  ds3_idle_integ #(.THRESH(THRESH)) u_integ (
    .clk(clk), .rst_n(rst_n), .eof(eof), .qual(qual),
    .cnt(idle_cnt), .idle(idle), .idle_irq(idle_irq)
  );

  ds3_ferf_det u_ferf (
    .clk(clk), .rst_n(rst_n), .eof(eof), .x_bits(x_bits),
    .ferf(ferf), .ferf_irq(ferf_irq)
  );

  assign stat_byte = {ais_in, los_in, idle, oof_in, 1'b0, cfg_in};
endmodule

// File: rtl/ds3_idle_ferf_chk.sv
module ds3_idle_ferf_chk #(
  parameter int THRESH = 63
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        eof,
  input logic [1:0]                  x_bits,
  input logic                        qual,
  input logic [$clog2(THRESH+1)-1:0] cnt,
  input logic                        idle,
  input logic                        ferf,
  input logic                        idle_irq,
  input logic                        ferf_irq
);
  // Input assumption: strobes are never back to back.
  p_eof_gap_in: assert property (@(posedge clk) disable iff (!rst_n) eof |=> !eof);

  p_cnt_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= THRESH);
  p_cnt_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !qual && cnt == 0) |=> cnt == 0);
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && qual && cnt == THRESH) |=> cnt == THRESH);

  p_idle_on_r5: assert property (@(posedge clk) disable iff (!rst_n) (cnt == THRESH) |-> idle);
  p_idle_off_r5: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 0) |-> !idle);

  p_idle_irq_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle != $past(idle)) |-> idle_irq);
  p_idle_irq_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |-> (idle != $past(idle)));

  p_ferf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && x_bits == 2'b00) |=> ferf);
  p_ferf_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && x_bits != 2'b00) |=> !ferf);
  p_ferf_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ferf_irq |-> (ferf != $past(ferf)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> ($stable(cnt) && $stable(idle) && $stable(ferf)));
endmodule

bind ds3_idle_ferf_mon ds3_idle_ferf_chk #(.THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .eof(eof), .x_bits(x_bits), .qual(qual),
  .cnt(idle_cnt), .idle(idle), .ferf(ferf), .idle_irq(idle_irq), .ferf_irq(ferf_irq)
);

// File: tb/ds3_idle_ferf_mon_bench.sv
`timescale 1ns/1ps
module ds3_idle_ferf_mon_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n = 1'b0;
  logic eof = 0, m_ok = 0, f_ok = 0, p_ok = 0, pay_valid = 0, pay_bit = 0;
  logic [2:0] cp_bits = 0, cfg_in = 0;
  logic [1:0] x_bits = 0;
  logic ais_in = 0, los_in = 0, oof_in = 0;
  logic pay_ready, idle, ferf, idle_irq, ferf_irq;
  logic [7:0] stat_byte;

  ds3_idle_ferf_mon u_ds3_idle_ferf_mon (
    .clk(clk), .rst_n(rst_n), .eof(eof), .m_ok(m_ok), .f_ok(f_ok), .p_ok(p_ok),
    .cp_bits(cp_bits), .x_bits(x_bits), .pay_valid(pay_valid), .pay_bit(pay_bit),
    .pay_ready(pay_ready), .ais_in(ais_in), .los_in(los_in), .oof_in(oof_in),
    .cfg_in(cfg_in), .idle(idle), .ferf(ferf), .idle_irq(idle_irq),
    .ferf_irq(ferf_irq), .stat_byte(stat_byte)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, run_cmp = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_cnt = 0;
  bit  m_idle = 0, m_ferf = 0, m_iirq = 0, m_firq = 0;
  bit  q[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idle = 0; m_ferf = 0; m_iirq = 0; m_firq = 0; q.delete();
    end else begin
      m_iirq = 0; m_firq = 0;
      if (eof) begin
        bit ok, prev;
        if (pay_valid) q.push_back(pay_bit);
        ok = 1;
        for (int i = 2; i < q.size(); i++) if (q[i] == q[i-2]) ok = 0;
        ok = ok && m_ok && f_ok && p_ok && cp_bits == 0 && x_bits == 2'b11;
        if (ok) m_cnt = (m_cnt < 63) ? m_cnt + 1 : 63;
        else    m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
        prev = m_idle;
        if (m_cnt == 63) m_idle = 1;
        if (m_cnt == 0)  m_idle = 0;
        m_iirq = (prev != m_idle);
        prev = m_ferf;
        m_ferf = (x_bits == 2'b00);
        m_firq = (prev != m_ferf);
        q.delete();
      end else if (pay_valid) q.push_back(pay_bit);
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(idle == m_idle, "R5 idle", idle, m_idle);
      chk(idle_irq == m_iirq, "R6 idle_irq", idle_irq, m_iirq);
      chk(ferf == m_ferf, "R7 ferf", ferf, m_ferf);
      chk(ferf_irq == m_firq, "R7 ferf_irq", ferf_irq, m_firq);
      chk(stat_byte == {ais_in, los_in, m_idle, oof_in, 1'b0, cfg_in}, "R9 stat_byte",
          stat_byte, {ais_in, los_in, m_idle, oof_in, 1'b0, cfg_in});
      chk(pay_ready == 1'b1, "R10 pay_ready", pay_ready, 1);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic pbit(input int ph, input int k);
    return ((k + ph) % 4) < 2;
  endfunction

  task automatic step();
    @(posedge clk); #1;
    {ais_in, los_in, oof_in, cfg_in} = 6'($urandom);
  endtask

  // One M-frame; between strobes the overhead inputs carry junk (R8).
  task automatic frame(input int ph, input int n, input logic [2:0] cp, input logic [1:0] x,
                       input logic [2:0] oks, input int bad, input bit last_in_eof);
    for (int k = 0; k < n; k++) begin
      if (k % 5 == 3) begin
        step(); pay_valid = 0;
      end
      step();
      x_bits = 2'b00; cp_bits = 3'($urandom); {m_ok, f_ok, p_ok} = 3'b000;
      pay_valid = 1; pay_bit = pbit(ph, k) ^ (k == bad);
    end
    step();
    eof = 1; {m_ok, f_ok, p_ok} = oks; cp_bits = cp; x_bits = x;
    pay_valid = last_in_eof; pay_bit = pbit(ph, n) ^ (n == bad);
    step();
    eof = 0; pay_valid = 0; x_bits = 2'b00;
    step();
  endtask

  task automatic good(input int cnt_frames);
    for (int i = 0; i < cnt_frames; i++) frame(i % 4, 12, 3'b000, 2'b11, 3'b111, -1, (i % 3) == 0);
  endtask

  task automatic plain_bad(input int cnt_frames);
    for (int i = 0; i < cnt_frames; i++) frame(0, 12, 3'b000, 2'b10, 3'b111, -1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(idle == 0, "R1 idle", idle, 0);
    chk(ferf == 0, "R1 ferf", ferf, 0);
    chk(idle_irq == 0 && ferf_irq == 0, "R1 irq", {idle_irq, ferf_irq}, 0);
    rst_n = 1; run_cmp = 1;

    good(62);
    chk(idle == 0, "R4 below ceiling", idle, 0);
    chk(ferf == 0, "R8 x junk between strobes ignored", ferf, 0);
    good(1);
    chk(idle == 1, "R5 declare at 63", idle, 1);
    good(10);   // saturates at 63 (R4)
    for (int i = 0; i < 62; i++) frame(1, 12, 3'b000, 2'b00, 3'b111, -1, 0);
    chk(idle == 1, "R4 saturation held count at 63", idle, 1);
    chk(ferf == 1, "R7 ferf set on x=00", ferf, 1);
    frame(1, 12, 3'b000, 2'b00, 3'b111, -1, 0);
    chk(idle == 0, "R5 clear at 0", idle, 0);
    frame(2, 12, 3'b000, 2'b11, 3'b111, -1, 0);
    chk(ferf == 0, "R7 ferf cleared", ferf, 0);
    frame(2, 12, 3'b000, 2'b11, 3'b111, -1, 0);
    plain_bad(5);   // back to 0; floor holds (R4)

    // R2 / R3: each disqualifier at count 62 stops the declare
    for (int kind = 0; kind < 7; kind++) begin
      good(62);
      case (kind)
        0: frame(0, 12, 3'b000, 2'b11, 3'b011, -1, 0);
        1: frame(1, 12, 3'b000, 2'b11, 3'b101, -1, 0);
        2: frame(2, 12, 3'b000, 2'b11, 3'b110, -1, 0);
        3: frame(3, 12, 3'b100, 2'b11, 3'b111, -1, 0);
        4: frame(0, 12, 3'b000, 2'b01, 3'b111, -1, 0);
        5: frame(1, 12, 3'b000, 2'b11, 3'b111, 5, 0);
        default: frame(2, 11, 3'b000, 2'b11, 3'b111, 11, 1);
      endcase
      good(1);
      chk(idle == 0, $sformatf("R2 R3 disqualifier %0d", kind), idle, 0);
      frame(3, 2, 3'b000, 2'b11, 3'b111, -1, 0);   // short frame passes (R3)
      chk(idle == 1, "R3 short frame qualifies R11", idle, 1);
      plain_bad(63);
      chk(idle == 0, "R5 cleared after 63 non-idle", idle, 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule